// File: doc/BRIEF.md
# Click-to-Cycle Cell Write Buffer

This block turns a pointer click on a cell grid into a single-cell write to state memory. Each grid cell holds one of four 2-bit states, and one memory word holds every row of a single column. When the pointer clicks on a valid cell, the block stores that cell's row and column. It then watches a read bus that another agent drives and waits until the word for the stored column goes past. From that word it takes the clicked cell's current state and works out the next state in a four-step cycle. It then writes the new state back, addressed to the column and masked to the single row.

The block never starts a read of its own, so it adds no traffic to the memory port. A write goes out only while an external access-window input allows it. Until then, the computed value stays pending. Only one click can be pending at a time.

Top module: `cell_click_writer`

## Requirements
- R1: After reset no write is pending: `wr_en_o` is all zero, and read-bus activity alone produces no write.
- R2: A click accepted while idle captures `ptr_col_i`/`ptr_row_i` as the target. Pointer movement after that cycle does not change the cell that gets written.
- R3: The value is taken only from a read-bus cycle with `rd_valid_i` high and `rd_addr_i` equal to the target column. Cycles for other columns, and cycles with `rd_valid_i` low, are ignored. No write happens before such a match.
- R4: The written state is (sniffed state + 1) mod 4, so 3 becomes 0. The sniffed state is bits [2r+1:2r] of `rd_data_i` for target row r. `wr_data_o` carries the new state in bits [2r+1:2r] and zero in every other field.
- R5: During a write, `wr_addr_o` equals the target column and `wr_en_o` has exactly bit r set. In any other cycle `wr_en_o`, `wr_addr_o` and `wr_data_o` are zero.
- R6: A captured value is written only in a cycle where `wr_window_i` is high. While the window is low it stays pending for as many cycles as needed. Each click produces exactly one write cycle, and the block is idle after that cycle.
- R7: A click that arrives while a click is pending is ignored. This includes the cycle in which the pending write is issued.
- R8: A click whose column is at least GRID_COLS, or whose row is at least GRID_ROWS, is discarded and leaves the block idle.
- R9: Once the value is captured, later read-bus cycles for the target column do not change the value that will be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| click_i | input | 1 | Single-cycle click pulse |
| ptr_col_i | input | COORD_W | Mapped pointer column |
| ptr_row_i | input | COORD_W | Mapped pointer row |
| rd_valid_i | input | 1 | Shared read bus carries a word this cycle |
| rd_addr_i | input | COL_W | Column address of the word on the read bus |
| rd_data_i | input | 2*GRID_ROWS | Column word; row r in bits [2r+1:2r] |
| wr_window_i | input | 1 | Writes to memory are permitted this cycle |
| wr_addr_o | output | COL_W | Write column address |
| wr_data_o | output | 2*GRID_ROWS | Write word, only the target row field non-zero |
| wr_en_o | output | GRID_ROWS | One-hot row write enable |

## Verification
Two functions can land in the same cycle: accepting a click, and issuing the pending write that frees the block. The bench holds a pending value, then raises the access window in the same cycle as a new click on a different cell. It checks that the original write appears with the original row, column and value. It then shows that the new click was dropped: it puts the new click's column on the read bus with the window open and sees no second write. A similar collision, a repeated read-bus match for the target column after the value was captured, is checked by confirming that the first sniffed value is the one written.

// File: rtl/cwb_pkg.sv
package cwb_pkg;

  localparam int CELL_W = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_READY = 2'd2
  } cwb_state_e;

  // Four-state cycle: 0 -> 1 -> 2 -> 3 -> 0
  function automatic logic [CELL_W-1:0] cell_advance(input logic [CELL_W-1:0] cur);
    return cur + 2'd1;
  endfunction

endpackage

// File: rtl/cwb_target_latch.sv
module cwb_target_latch #(
  parameter int GRID_COLS = 16,
  parameter int GRID_ROWS = 8,
  parameter int COORD_W   = 6,
  parameter int COL_W     = 4,
  parameter int ROW_W     = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               click_i,
  input  logic               busy_i,
  input  logic [COORD_W-1:0] ptr_col_i,
  input  logic [COORD_W-1:0] ptr_row_i,
  output logic               take_o,
  output logic [COL_W-1:0]   col_o,
  output logic [ROW_W-1:0]   row_o
);

  localparam logic [COORD_W-1:0] COL_LIM = COORD_W'(GRID_COLS);
  localparam logic [COORD_W-1:0] ROW_LIM = COORD_W'(GRID_ROWS);

  logic in_range;

  assign in_range = (ptr_col_i < COL_LIM) && (ptr_row_i < ROW_LIM);
  assign take_o   = click_i && !busy_i && in_range;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_o <= '0;
      row_o <= '0;
    end else if (take_o) begin
      col_o <= ptr_col_i[COL_W-1:0];
      row_o <= ptr_row_i[ROW_W-1:0];
    end
  end

  // R7: a click while busy must not move the target
  a_r7_target_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> ($stable(col_o) && $stable(row_o)));

  // R8: an out-of-range coordinate is never taken
  a_r8_range_gate: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (32'(ptr_col_i) < GRID_COLS) && (32'(ptr_row_i) < GRID_ROWS));

endmodule

// File: rtl/cwb_sniffer.sv
module cwb_sniffer
  import cwb_pkg::*;
#(
  parameter int GRID_ROWS = 8,
  parameter int COL_W     = 4,
  parameter int ROW_W     = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        arm_i,
  input  logic [COL_W-1:0]            tgt_col_i,
  input  logic [ROW_W-1:0]            tgt_row_i,
  input  logic                        rd_valid_i,
  input  logic [COL_W-1:0]            rd_addr_i,
  input  logic [GRID_ROWS*CELL_W-1:0] rd_data_i,
  output logic                        hit_o,
  output logic [CELL_W-1:0]           next_o
);

  logic [CELL_W-1:0] cells [GRID_ROWS];
  logic [CELL_W-1:0] cur;

  for (genvar g = 0; g < GRID_ROWS; g++) begin : g_cell
    assign cells[g] = rd_data_i[g*CELL_W +: CELL_W];
  end

  assign cur   = cells[tgt_row_i];
  assign hit_o = arm_i && rd_valid_i && (rd_addr_i == tgt_col_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_o <= '0;
    end else if (hit_o) begin
      next_o <= cell_advance(cur);
    end
  end

  // R4: the stored value always differs from the sniffed one
  a_r4_changes: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |=> (next_o != $past(cur)));

  // R4: state 3 wraps to state 0
  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o && cur == 2'd3) |=> (next_o == 2'd0));

  // R9: without a hit the captured value holds
  a_r9_value_held: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_o |=> $stable(next_o));

endmodule

// File: rtl/cwb_issue.sv
module cwb_issue
  import cwb_pkg::*;
#(
  parameter int GRID_ROWS = 8,
  parameter int COL_W     = 4,
  parameter int ROW_W     = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ready_i,
  input  logic                        window_i,
  input  logic [COL_W-1:0]            col_i,
  input  logic [ROW_W-1:0]            row_i,
  input  logic [CELL_W-1:0]           val_i,
  output logic                        fire_o,
  output logic [COL_W-1:0]            wr_addr_o,
  output logic [GRID_ROWS*CELL_W-1:0] wr_data_o,
  output logic [GRID_ROWS-1:0]        wr_en_o
);

  assign fire_o    = ready_i && window_i;
  assign wr_addr_o = fire_o ? col_i : '0;

  for (genvar g = 0; g < GRID_ROWS; g++) begin : g_row
    logic sel;
    assign sel                          = fire_o && (row_i == ROW_W'(g));
    assign wr_en_o[g]                   = sel;
    assign wr_data_o[g*CELL_W +: CELL_W] = sel ? val_i : '0;
  end

  // R5: at most one row enabled
  a_r5_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en_o));

  // R6: enables only inside the access window
  a_r6_window_only: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o != '0) |-> window_i);

  // R5: idle bus is all zero
  a_r5_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o == '0) |-> (wr_data_o == '0 && wr_addr_o == '0));

endmodule

// File: rtl/cell_click_writer.sv
module cell_click_writer
  import cwb_pkg::*;
#(
  parameter int GRID_COLS = 16,
  parameter int GRID_ROWS = 8,
  parameter int COORD_W   = 6,
  localparam int COL_W    = (GRID_COLS > 1) ? $clog2(GRID_COLS) : 1,
  localparam int ROW_W    = (GRID_ROWS > 1) ? $clog2(GRID_ROWS) : 1,
  localparam int WORD_W   = GRID_ROWS * CELL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               click_i,
  input  logic [COORD_W-1:0] ptr_col_i,
  input  logic [COORD_W-1:0] ptr_row_i,
  input  logic               rd_valid_i,
  input  logic [COL_W-1:0]   rd_addr_i,
  input  logic [WORD_W-1:0]  rd_data_i,
  input  logic               wr_window_i,
  output logic [COL_W-1:0]   wr_addr_o,
  output logic [WORD_W-1:0]  wr_data_o,
  output logic [GRID_ROWS-1:0] wr_en_o
);

  cwb_state_e state_q, state_d;

  // Named internal events
  logic             click_take;
  logic             sniff_hit;
  logic             write_fire;
  logic             busy;
  logic [COL_W-1:0] tgt_col;
  logic [ROW_W-1:0] tgt_row;
  logic [CELL_W-1:0] next_val;

  assign busy = (state_q != ST_IDLE);

  cwb_target_latch #(
    .GRID_COLS(GRID_COLS), .GRID_ROWS(GRID_ROWS), .COORD_W(COORD_W),
    .COL_W(COL_W), .ROW_W(ROW_W)
  ) i_latch (
    .clk(clk), .rst_n(rst_n), .click_i(click_i), .busy_i(busy),
    .ptr_col_i(ptr_col_i), .ptr_row_i(ptr_row_i),
    .take_o(click_take), .col_o(tgt_col), .row_o(tgt_row)
  );

  cwb_sniffer #(
    .GRID_ROWS(GRID_ROWS), .COL_W(COL_W), .ROW_W(ROW_W)
  ) i_sniff (
    .clk(clk), .rst_n(rst_n), .arm_i(state_q == ST_WAIT),
    .tgt_col_i(tgt_col), .tgt_row_i(tgt_row),
    .rd_valid_i(rd_valid_i), .rd_addr_i(rd_addr_i), .rd_data_i(rd_data_i),
    .hit_o(sniff_hit), .next_o(next_val)
  );

  cwb_issue #(
    .GRID_ROWS(GRID_ROWS), .COL_W(COL_W), .ROW_W(ROW_W)
  ) i_issue (
    .clk(clk), .rst_n(rst_n), .ready_i(state_q == ST_READY),
    .window_i(wr_window_i), .col_i(tgt_col), .row_i(tgt_row),
    .val_i(next_val), .fire_o(write_fire),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .wr_en_o(wr_en_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (click_take) state_d = ST_WAIT;
      ST_WAIT:  if (sniff_hit)  state_d = ST_READY;
      ST_READY: if (write_fire) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // R3: no write while still waiting for the target word
  a_r3_wait_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT) |-> (wr_en_o == '0));

  // R6: one write cycle per click, then idle
  a_r6_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    write_fire |=> (wr_en_o == '0 && state_q == ST_IDLE));

  // R8: a rejected click while idle leaves the block idle
  a_r8_discard: assert property (@(posedge clk) disable iff (!rst_n)
    (click_i && state_q == ST_IDLE && !click_take) |=> (state_q == ST_IDLE));

  // R2: an accepted click always leads to a pending state
  a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
    click_take |=> (state_q == ST_WAIT));

endmodule

// File: tb/test_cell_click_writer.sv
`timescale 1ns/1ps
module test_cell_click_writer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        click = 1'b0;
  logic [5:0]  pcol = '0;
  logic [5:0]  prow = '0;
  logic        rd_valid = 1'b0;
  logic [3:0]  rd_addr = '0;
  logic [15:0] rd_data = '0;
  logic        win = 1'b0;
  logic [3:0]  wr_addr;
  logic [15:0] wr_data;
  logic [7:0]  wr_en;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  cell_click_writer i_cell_click_writer (
    .clk(clk), .rst_n(rst_n), .click_i(click), .ptr_col_i(pcol), .ptr_row_i(prow),
    .rd_valid_i(rd_valid), .rd_addr_i(rd_addr), .rd_data_i(rd_data),
    .wr_window_i(win), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_en_o(wr_en)
  );

  task automatic expect_eq(input string req, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // Column word with every field = fill, field `row` = val
  function automatic logic [15:0] mk_word(input int row, input logic [1:0] val,
                                          input logic [1:0] fill);
    logic [15:0] w;
    for (int i = 0; i < 8; i++) w[2*i +: 2] = fill;
    w[2*row +: 2] = val;
    return w;
  endfunction

  function automatic logic [15:0] exp_wr(input int row, input logic [1:0] val);
    logic [15:0] w = '0;
    w[2*row +: 2] = val;
    return w;
  endfunction

  task automatic do_click(input int col, input int row);
    step();
    click = 1'b1; pcol = 6'(col); prow = 6'(row);
    step();
    click = 1'b0;
  endtask

  // One read-bus cycle; no write may appear while the word is being sniffed
  task automatic sniff(input int col, input logic [15:0] word, input string req);
    rd_valid = 1'b1; rd_addr = 4'(col); rd_data = word;
    #1;
    expect_eq(req, "no write during sniff", 32'(wr_en), 32'h0);
    step();
    rd_valid = 1'b0;
  endtask

  task automatic expect_write(input string req, input int col, input int row,
                              input logic [1:0] val);
    #1;
    expect_eq(req, "wr_en", 32'(wr_en), 32'(8'h1 << row));
    expect_eq(req, "wr_addr", 32'(wr_addr), 32'(col));
    expect_eq(req, "wr_data", 32'(wr_data), 32'(exp_wr(row, val)));
  endtask

  task automatic expect_idle_bus(input string req);
    #1;
    expect_eq(req, "wr_en idle", 32'(wr_en), 32'h0);
    expect_eq(req, "wr_data idle", 32'(wr_data), 32'h0);
  endtask

  task automatic t_reset();
    // R1: idle after reset, bus activity alone writes nothing
    win = 1'b1;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    expect_idle_bus("R1");
    rd_valid = 1'b1; rd_addr = 4'd0; rd_data = 16'hFFFF;
    step();
    rd_valid = 1'b0;
    step();
    expect_idle_bus("R1");
  endtask

  task automatic t_basic();
    // R2, R4, R5, R6: click then pointer moves away
    win = 1'b1;
    do_click(5, 3);
    pcol = 6'd11; prow = 6'd6;
    sniff(5, mk_word(3, 2'd0, 2'd2), "R3");
    expect_write("R2", 5, 3, 2'd1);
    step();
    expect_idle_bus("R6");
  endtask

  task automatic t_values();
    // R4: wrap 3 -> 0 at row 7 and 2 -> 3 at row 0 at edge columns
    win = 1'b1;
    do_click(0, 7);
    sniff(0, mk_word(7, 2'd3, 2'd1), "R3");
    expect_write("R4", 0, 7, 2'd0);
    step();
    do_click(15, 0);
    sniff(15, mk_word(0, 2'd2, 2'd1), "R3");
    expect_write("R4", 15, 0, 2'd3);
    step();
    expect_idle_bus("R5");
  endtask

  task automatic t_other_cols();
    // R3: other column and invalid cycles are ignored
    win = 1'b1;
    do_click(9, 2);
    sniff(8, mk_word(2, 2'd1, 2'd0), "R3");
    expect_idle_bus("R3");
    rd_valid = 1'b0; rd_addr = 4'd9; rd_data = mk_word(2, 2'd3, 2'd0);
    step();
    expect_idle_bus("R3");
    sniff(9, mk_word(2, 2'd1, 2'd0), "R3");
    expect_write("R3", 9, 2, 2'd2);
    step();
  endtask

  task automatic t_window();
    // R6: pending value waits for the window
    win = 1'b0;
    do_click(3, 4);
    sniff(3, mk_word(4, 2'd2, 2'd0), "R3");
    for (int i = 0; i < 5; i++) begin
      #1;
      expect_eq("R6", "held while window low", 32'(wr_en), 32'h0);
      step();
    end
    win = 1'b1;
    expect_write("R6", 3, 4, 2'd3);
    step();
    win = 1'b0;
    expect_idle_bus("R6");
  endtask

  task automatic t_busy();
    // R7: clicks while pending, including the write cycle, are dropped
    win = 1'b0;
    do_click(1, 1);
    do_click(2, 2);
    sniff(2, mk_word(2, 2'd0, 2'd0), "R7");
    win = 1'b1;
    #1;
    expect_eq("R7", "second click not taken", 32'(wr_en), 32'h0);
    win = 1'b0;
    sniff(1, mk_word(1, 2'd1, 2'd0), "R7");
    win = 1'b1; click = 1'b1; pcol = 6'd6; prow = 6'd6;
    expect_write("R7", 1, 1, 2'd2);
    step();
    click = 1'b0;
    sniff(6, mk_word(6, 2'd0, 2'd0), "R7");
    expect_idle_bus("R7");
    step();
    expect_idle_bus("R7");
  endtask

  task automatic t_range();
    // R8: out-of-range column / row are discarded
    win = 1'b1;
    do_click(16, 0);
    sniff(0, mk_word(0, 2'd0, 2'd0), "R8");
    expect_idle_bus("R8");
    do_click(2, 8);
    sniff(2, mk_word(0, 2'd0, 2'd0), "R8");
    expect_idle_bus("R8");
    do_click(15, 7);
    sniff(15, mk_word(7, 2'd1, 2'd3), "R8");
    expect_write("R8", 15, 7, 2'd2);
    step();
  endtask

  task automatic t_stale();
    // R9: a later matching word does not replace the captured value
    win = 1'b0;
    do_click(4, 5);
    sniff(4, mk_word(5, 2'd1, 2'd0), "R9");
    sniff(4, mk_word(5, 2'd3, 2'd0), "R9");
    win = 1'b1;
    expect_write("R9", 4, 5, 2'd2);
    step();
    win = 1'b0;
  endtask

  initial begin
    t_reset();
    t_basic();
    t_values();
    t_other_cols();
    t_window();
    t_busy();
    t_range();
    t_stale();
    step();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule